// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

This block runs a set of dual-purpose pins that are configuration inputs right after power-up and clock outputs for the rest of the power cycle. When the supply is declared good, the controller keeps every shared pin's output driver off for a timed window. During that window, external pull resistors set the level on each pin. On the last tick of the window it captures the synchronised pin levels into a strap register. One cycle later it turns on the output drivers. From then on the strap register is frozen until power-good drops.

The strap register has five bits. The low four bits form a frequency-select code. The top bit is a spare mode strap. The controller also outputs the effective four-bit frequency code. That code is taken either from the captured straps or from a software-owned select field, as chosen by a source bit. Each pin's drive value is its clock source while the pin is enabled, and is held low before that.

Top module: `strap_sample_ctrl`

## Requirements
- R1: While `pwr_good` is low, `pin_oe`, `pin_drive`, `strap_q` and `sample_done` are all zero, and this takes effect asynchronously.
- R2: `pwr_good` is synchronised by two flops. The window counter runs on the clock edges that follow. `pin_oe` stays zero through the first WIN_TICKS+2 rising edges at which `pwr_good` is seen high.
- R3: `pin_in` passes through a two-flop synchroniser. At edge WIN_TICKS+2 after power-good, `strap_q` loads the `pin_in` value that was sampled at edge WIN_TICKS. Bit i of `strap_q` corresponds to bit i of `pin_in`.
- R4: All `pin_oe` bits go high together at edge WIN_TICKS+3, one edge after the capture, and stay high until power-good drops.
- R5: After the capture, `strap_q` does not change for the rest of the power cycle, whatever `pin_in`, `reg_src` or `reg_code` do.
- R6: `sample_done` rises at the same edge as `pin_oe` (one cycle after the capture) and remains set until `pwr_good` falls.
- R7: `freq_code` equals `reg_code` when `reg_src` is 1, and `strap_q[3:0]` when `reg_src` is 0. Strap bit 4 never enters the code.
- R8: `pin_drive[i]` equals `clk_src[i]` while `pin_oe[i]` is 1, and 0 otherwise.
- R9: If `pwr_good` drops during the window, the window starts again from zero at the next power-good, and the straps are then sampled afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| pwr_good | input | 1 | Supply-good indication, asynchronous, active high |
| pin_in | input | 5 | Levels read back from the shared pins |
| clk_src | input | 5 | Clock source for each pin once it drives |
| reg_src | input | 1 | Code source: 0 selects straps, 1 selects register field |
| reg_code | input | 4 | Software frequency select field |
| pin_oe | output | 5 | Output-driver enable per pin |
| pin_drive | output | 5 | Value driven on each pin |
| strap_q | output | 5 | Captured strap bits |
| freq_code | output | 4 | Effective frequency-select code |
| sample_done | output | 1 | Capture finished for this power cycle |

## Verification
Four properties are checked on every cycle after reset release. The strap register holds once captured. The done flag is sticky and implies a capture. No driver is enabled before the capture. The capture happens only at the terminal window count. Only the bench scenarios can show the following behaviours: the exact edge at which a pin value is captured through the synchroniser, the restart after a power-good drop in mid-window, the code multiplexing, and the fact that pin changes after the capture have no effect.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned STRAP_PINS = 5;
  localparam int unsigned CODE_BITS  = 4;
  // 2 ms at a 50 MHz sampling clock
  localparam int unsigned WIN_DEFAULT = 100000;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk,
  input  logic pwr_good,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/strap_pin_sync.sv
module strap_pin_sync #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic m_q, o_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= 1'b0;
        o_q <= 1'b0;
      end else begin
        m_q <= d[i];
        o_q <= m_q;
      end
    end
    assign q[i] = o_q;
  end
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned WIN_TICKS = 100000,
  localparam int unsigned CNT_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  output logic [CNT_W-1:0] cnt,
  output logic             last_tick
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  assign at_max    = (cnt_q == CNT_MAX);
  assign last_tick = at_max && !stop;

  always_comb begin
    cnt_d = cnt_q;
    if (!stop && !at_max) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [WIDTH-1:0] pins_sync,
  output logic             captured,
  output logic             done,
  output logic [WIDTH-1:0] strap_q
);
  logic             cap_q, cap_d, done_q, done_d;
  logic [WIDTH-1:0] strap_r, strap_d;

  always_comb begin
    cap_d   = cap_q | take;
    done_d  = cap_q;
    strap_d = strap_r;
    if (take) strap_d = pins_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      done_q  <= 1'b0;
      strap_r <= '0;
    end else begin
      cap_q   <= cap_d;
      done_q  <= done_d;
      strap_r <= strap_d;
    end
  end

  assign captured = cap_q;
  assign done     = done_q;
  assign strap_q  = strap_r;

  // R5: straps frozen after capture
  a_r5_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(strap_r));
  // R6: done is sticky and implies a capture
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  a_r6_done_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cap_q);
endmodule

// File: rtl/strap_sample_ctrl.sv
module strap_sample_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned NPINS     = STRAP_PINS,
  parameter int unsigned CODE_W    = CODE_BITS,
  parameter int unsigned WIN_TICKS = WIN_DEFAULT
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  clk_src,
  input  logic              reg_src,
  input  logic [CODE_W-1:0] reg_code,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_drive,
  output logic [NPINS-1:0]  strap_q,
  output logic [CODE_W-1:0] freq_code,
  output logic              sample_done
);
  localparam int unsigned CNT_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_TICKS - 1);

  logic             rst_n;
  logic [NPINS-1:0] pins_sync;
  logic [CNT_W-1:0] cnt;
  logic             last_tick, captured, done;

  strap_rst_sync u_rst (
    .clk      (clk),
    .pwr_good (pwr_good),
    .rst_n    (rst_n)
  );

  strap_pin_sync #(.WIDTH(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  strap_window_timer #(.WIN_TICKS(WIN_TICKS)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (captured),
    .cnt       (cnt),
    .last_tick (last_tick)
  );

  strap_capture #(.WIDTH(NPINS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (last_tick),
    .pins_sync (pins_sync),
    .captured  (captured),
    .done      (done),
    .strap_q   (strap_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    assign pin_oe[i]    = done;
    assign pin_drive[i] = done & clk_src[i];
  end

  assign freq_code   = reg_src ? reg_code : strap_q[CODE_W-1:0];
  assign sample_done = done;

  // R2: no driver enabled before the capture
  a_r2_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> (pin_oe == '0));
  // R3: capture only on the terminal count of the window
  a_r3_cap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captured) |-> ($past(cnt) == CNT_MAX));
endmodule

// File: tb/tb_strap_sample_ctrl.sv
module tb_strap_sample_ctrl;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       pwr_good;
  logic [4:0] pin_in, clk_src;
  logic       reg_src;
  logic [3:0] reg_code;
  logic [4:0] pin_oe, pin_drive, strap_q;
  logic [3:0] freq_code;
  logic       sample_done;

  int n_vec = 0;
  int n_bad = 0;

  strap_sample_ctrl #(.WIN_TICKS(WIN)) dut (
    .clk(clk), .pwr_good(pwr_good), .pin_in(pin_in), .clk_src(clk_src),
    .reg_src(reg_src), .reg_code(reg_code), .pin_oe(pin_oe),
    .pin_drive(pin_drive), .strap_q(strap_q), .freq_code(freq_code),
    .sample_done(sample_done)
  );

  always #10 clk = ~clk;

  // behavioural reference: edges seen with power good, and pin history
  int         edges = 0;
  logic [4:0] hist[$];

  always @(posedge clk) begin
    if (pwr_good) begin
      edges <= edges + 1;
      if (hist.size() < WIN + 4) hist.push_back(pin_in);
    end else begin
      edges <= 0;
      hist.delete();
    end
  end

  task automatic cmp(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [4:0] e_strap, e_oe;
    logic       e_done;
    logic [3:0] e_code;
    if (!pwr_good) begin
      e_strap = '0; e_done = 1'b0;                      // R1
    end else begin
      e_strap = (edges >= WIN + 2) ? hist[WIN-1] : 5'b0; // R3 R5 R9
      e_done  = (edges >= WIN + 3);                      // R6
    end
    e_oe   = {5{e_done}};                                // R2 R4
    e_code = reg_src ? reg_code : e_strap[3:0];          // R7
    cmp("R3/R5 strap_q", strap_q, e_strap);
    cmp("R2/R4 pin_oe", pin_oe, e_oe);
    cmp("R6 sample_done", {4'b0, sample_done}, {4'b0, e_done});
    cmp("R7 freq_code", {1'b0, freq_code}, {1'b0, e_code});
    cmp("R8 pin_drive", pin_drive, e_oe & clk_src);
  end

  always @(posedge clk) #1 clk_src <= clk_src + 5'd7;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    pwr_good = 1'b0; pin_in = 5'b10110; clk_src = 5'b0;
    reg_src = 1'b0; reg_code = 4'h9;
    fork
      begin
        // R1: held in reset
        step(4);
        pwr_good = 1'b1;
        // R3: pins move near the end of the window
        step(WIN - 2);
        pin_in = 5'b01101;
        step(1);
        pin_in = 5'b11011;
        step(3);
        pin_in = 5'b00100;
        step(8);
        // R5 R7: pin and register activity after capture
        pin_in = 5'b11111; reg_code = 4'h3; step(3);
        reg_src = 1'b1; step(3);
        reg_code = 4'hC; step(2);
        reg_src = 1'b0; step(3);
        // R1 R9: drop during the window restarts it
        pwr_good = 1'b0; step(3);
        pwr_good = 1'b1; pin_in = 5'b01010; step(8);
        pwr_good = 1'b0; step(2);
        pwr_good = 1'b1; pin_in = 5'b00011; step(WIN + 10);
        reg_src = 1'b1; reg_code = 4'h5; step(4);
        pwr_good = 1'b0; step(4);
      end
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule